// File: doc/BRIEF.md
# Card Session Interrupt Flag

This block drives the active-low interrupt line that a smart card interface gives to its host controller. The meaning of the line depends on whether a card session is open. While the host holds its session command inactive, the line reports whether a card is inserted. While a session is open, the line drops when the card is pulled out or when any fault input fires. In the cycle the line is first pulled low inside a session, the block also sends a one-cycle start pulse to the deactivation sequencer.

The line is modelled as the enable of an open-drain pull-down, so `flag_pd_en` high means the line is low. The session command and the presence input are asynchronous to the clock and each passes through its own two-flop synchronizer. The fault inputs are taken as already synchronous to `clk`.

Once a session trips, the flag stays low for the rest of that session, even after the cause has gone away. The block issues no second deactivation pulse until the host closes the session and opens a new one. There are no data streams, so every pin is a plain level or pulse signal with no handshake.

Top module: `card_irq_flag`

## Requirements
- R1: While `rst` is high, `flag_pd_en` and `deact_req` are 0 at every clock edge. After reset, the synchronizers hold "no session, card present", so the pull-down stays disabled until real input values arrive.
- R2: When `sess_cmd_n` is 1 (no session), `flag_pd_en` equals the inverse of `card_present`. A change on `card_present` appears on `flag_pd_en` at the third rising edge after the change: two synchronizer stages, then the output register.
- R3: When no session is open, `fault_in` has no effect on `flag_pd_en`, and `deact_req` never goes high.
- R4: When `sess_cmd_n` is 0 (session open) and `card_present` drops to 0, `flag_pd_en` becomes 1 at the third rising edge after the drop.
- R5: When a session is open and any bit of `fault_in` is 1 at a rising edge, `flag_pd_en` is 1 after that edge.
- R6: `deact_req` goes high in the same cycle that `flag_pd_en` is first asserted within a session. `deact_req` is never high while `flag_pd_en` is 0.
- R7: Each `deact_req` pulse lasts exactly one cycle. At most one pulse is issued per session, where a session is one unbroken stretch of synchronized `sess_cmd_n` = 0.
- R8: Within a session, once `flag_pd_en` is 1 it stays 1 until the session ends, even if the fault clears and the card returns.
- R9: When a session closes, `flag_pd_en` again follows card presence as in R2. A later session can trip again and issue a new pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sess_cmd_n | input | 1 | Host session command, active low, asynchronous |
| card_present | input | 1 | Debounced card presence, 1 = inserted, asynchronous |
| fault_in | input | NFAULT | Fault indicators, active high, synchronous to clk |
| flag_pd_en | output | 1 | Pull-down enable of the open-drain interrupt line (1 = line low) |
| deact_req | output | 1 | One-cycle start pulse for the deactivation sequencer |

## Verification
The main function is tried four ways:
- Presence toggles with no session open, which shows that the flag follows the card.
- Fault bits raised with no session open, which shows that faults are masked outside a session.
- Faults, extraction and their removal inside a session, which shows the trip, the latch and the single pulse.
- Sessions opened and closed back to back, which shows that the latch and the once-per-session limit are cleared properly.

Constrained random sequences then mix all four. They apply the session and presence change first and the fault change a few cycles later, so each cause can be tied to its own expected flag level and pulse count. Directed cases also pin down the exact cycle of each change.

// File: rtl/cif_pkg.sv
package cif_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_TRIPPED = 2'd2
  } sess_state_e;
endpackage

// File: rtl/cif_sync.sv
module cif_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else     chain[i] <= chain[i-1];
    end

    // R2: each stage delays its neighbour by one clock
    p_stage_shift_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> chain[i] == $past(chain[i-1]));
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cif_fault_any.sv
module cif_fault_any #(
  parameter int NFAULT = 3
) (
  input  logic [NFAULT-1:0] fault_vec,
  output logic              any_fault
);
  logic [NFAULT-1:0] acc;

  assign acc[0] = fault_vec[0];
  for (genvar i = 1; i < NFAULT; i++) begin : g_or
    assign acc[i] = acc[i-1] | fault_vec[i];
  end

  assign any_fault = acc[NFAULT-1];
endmodule

// File: rtl/cif_session_fsm.sv
module cif_session_fsm
  import cif_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sess_act,
  input  logic pres,
  input  logic any_fault,
  output logic pd_en,
  output logic deact
);
  sess_state_e st, st_nx;
  logic        pd_nx, deact_nx;
  logic        trip;

  assign trip = !pres || any_fault;

  always_comb begin
    st_nx    = st;
    pd_nx    = pd_en;
    deact_nx = 1'b0;
    if (!sess_act) begin
      st_nx = ST_IDLE;
      pd_nx = !pres;
    end else begin
      unique case (st)
        ST_IDLE, ST_ARMED: begin
          if (trip) begin
            st_nx    = ST_TRIPPED;
            pd_nx    = 1'b1;
            deact_nx = 1'b1;
          end else begin
            st_nx = ST_ARMED;
            pd_nx = 1'b0;
          end
        end
        ST_TRIPPED: pd_nx = 1'b1;
        default: begin
          st_nx = ST_IDLE;
          pd_nx = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      pd_en <= 1'b0;
      deact <= 1'b0;
    end else begin
      st    <= st_nx;
      pd_en <= pd_nx;
      deact <= deact_nx;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!pd_en && !deact));
  p_outside_follows_pres_r2: assert property (@(posedge clk) disable iff (rst)
    !sess_act |=> (pd_en == !$past(pres)));
  p_outside_no_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    !sess_act |=> !deact);
  p_absent_trips_r4: assert property (@(posedge clk) disable iff (rst)
    (sess_act && !pres) |=> pd_en);
  p_fault_trips_r5: assert property (@(posedge clk) disable iff (rst)
    (sess_act && any_fault) |=> pd_en);
  p_pulse_with_flag_r6: assert property (@(posedge clk) disable iff (rst)
    deact |-> pd_en);
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
    deact |=> !deact);
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TRIPPED && sess_act) |=> pd_en);
endmodule

// File: rtl/card_irq_flag.sv
module card_irq_flag #(
  parameter int NFAULT      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sess_cmd_n,
  input  logic              card_present,
  input  logic [NFAULT-1:0] fault_in,
  output logic              flag_pd_en,
  output logic              deact_req
);
  logic cmd_n_s, pres_s, any_fault;
  logic sess_act;
  logic fired;

  cif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cmd (
    .clk(clk), .rst(rst), .d_async(sess_cmd_n), .q_sync(cmd_n_s));

  cif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pres (
    .clk(clk), .rst(rst), .d_async(card_present), .q_sync(pres_s));

  cif_fault_any #(.NFAULT(NFAULT)) u_fault_any (
    .fault_vec(fault_in), .any_fault(any_fault));

  assign sess_act = !cmd_n_s;

  cif_session_fsm u_fsm (
    .clk(clk), .rst(rst), .sess_act(sess_act), .pres(pres_s),
    .any_fault(any_fault), .pd_en(flag_pd_en), .deact(deact_req));

  // per-session pulse tracker used only by the R7 property
  always_ff @(posedge clk) begin
    if (rst || !sess_act) fired <= 1'b0;
    else if (deact_req)   fired <= 1'b1;
  end

  p_once_per_session_r7: assert property (@(posedge clk) disable iff (rst)
    deact_req |-> !fired);
  p_new_session_can_trip_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(sess_act) && sess_act && (!pres_s || any_fault)) |=> deact_req);
endmodule

// File: tb/card_irq_flag_bench.sv
module card_irq_flag_bench;
  localparam int NF = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sess_cmd_n = 1'b1;
  logic          card_present = 1'b1;
  logic [NF-1:0] fault_in = '0;
  logic          flag_pd_en, deact_req;

  int n_chk = 0, n_err = 0;
  int pulses = 0, wide = 0;
  logic prev_deact = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  card_irq_flag #(.NFAULT(NF), .SYNC_STAGES(2)) u_card_irq_flag (
    .clk(clk), .rst(rst), .sess_cmd_n(sess_cmd_n), .card_present(card_present),
    .fault_in(fault_in), .flag_pd_en(flag_pd_en), .deact_req(deact_req));

  always @(posedge clk) begin
    #2;
    if (deact_req) pulses++;
    if (deact_req && prev_deact) wide++;
    prev_deact = deact_req;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected flag level from requirements R2, R4, R5, R8
  function automatic logic exp_flag(logic cmd_n, logic pres, logic latched);
    return cmd_n ? !pres : latched;
  endfunction

  function automatic logic trips(logic pres, logic [NF-1:0] f);
    return !pres || (|f);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p0;
    logic t0, t1, t2, cmd_n, pres;
    logic [NF-1:0] oldf, newf;
    void'($urandom(32'h5eed_c0de));

    // R1 reset state
    step(3);
    chk("R1 pd during reset", flag_pd_en, 0);
    chk("R1 deact during reset", deact_req, 0);
    @(negedge clk) rst = 1'b0;
    step(1);
    chk("R1 pd right after reset", flag_pd_en, 0);
    step(4);

    // R2 exact latency: change at negedge, visible after third edge
    card_present = 1'b0;
    step(2);
    chk("R2 flag before sync", flag_pd_en, 0);
    step(1);
    chk("R2 flag card absent", flag_pd_en, 1);
    card_present = 1'b1;
    step(4);
    chk("R2 flag card present", flag_pd_en, 0);

    // R3 faults ignored outside a session
    p0 = pulses;
    fault_in = 3'b101;
    step(4);
    chk("R3 flag with fault outside", flag_pd_en, 0);
    chk("R3 no pulse outside", pulses - p0, 0);
    fault_in = '0;

    // open session, card present, no fault
    sess_cmd_n = 1'b0;
    step(5);
    chk("R4 armed session flag", flag_pd_en, 0);

    // R5 fault trips one edge later with the pulse in the same cycle (R6)
    p0 = pulses;
    fault_in = 3'b010;
    step(1);
    chk("R5 flag after fault", flag_pd_en, 1);
    chk("R6 pulse with flag", deact_req, 1);
    step(1);
    chk("R7 pulse one cycle", deact_req, 0);
    fault_in = '0;
    step(4);
    chk("R8 flag latched after clear", flag_pd_en, 1);
    fault_in = 3'b001;
    step(3);
    chk("R7 one pulse per session", pulses - p0, 1);

    // R9 leave session, follow presence, then new session extraction
    fault_in = '0;
    sess_cmd_n = 1'b1;
    step(4);
    chk("R9 flag released", flag_pd_en, 0);
    sess_cmd_n = 1'b0;
    step(5);
    p0 = pulses;
    card_present = 1'b0;
    step(2);
    chk("R4 before sync", flag_pd_en, 0);
    step(1);
    chk("R4 extraction trips", flag_pd_en, 1);
    chk("R6 pulse on extraction", deact_req, 1);
    card_present = 1'b1;
    step(5);
    chk("R8 latched after reinsertion", flag_pd_en, 1);
    chk("R9 new session pulse", pulses - p0, 1);
    sess_cmd_n = 1'b1;
    step(5);

    // constrained random: session/presence change, then fault change
    t0 = 1'b0;
    for (int it = 0; it < 400; it++) begin
      p0    = pulses;
      oldf  = fault_in;
      cmd_n = ($urandom_range(0, 3) != 0) ? sess_cmd_n : logic'($urandom_range(0, 1));
      pres  = ($urandom_range(0, 4) != 0);
      newf  = ($urandom_range(0, 3) == 0) ? NF'($urandom_range(0, 7)) : '0;
      sess_cmd_n   = cmd_n;
      card_present = pres;
      if (cmd_n) t0 = 1'b0;
      t1 = cmd_n ? 1'b0 : (t0 || trips(pres, oldf));
      step(4);
      chk(cmd_n ? "R2 random flag" : "R4 random flag", flag_pd_en, exp_flag(cmd_n, pres, t1));
      fault_in = newf;
      t2 = cmd_n ? 1'b0 : (t1 || (|newf));
      step(4);
      chk(cmd_n ? "R3 random flag" : "R5 random flag", flag_pd_en, exp_flag(cmd_n, pres, t2));
      chk(cmd_n ? "R3 random pulses" : "R7 random pulses", pulses - p0, (!t0 && t2) ? 1 : 0);
      t0 = t2;
    end
    chk("R7 no wide pulses", wide, 0);
    finish_run();
  end
endmodule